// File: doc/BRIEF.md
# Dual-Register Programmable Logic Cell

This block is one output cell of a sum-of-products programmable logic device. The shared AND array has already evaluated the product terms, and they arrive here as plain bits. The cell ORs twelve of them into sum terms. It feeds those sums into two flip-flops, each configurable as D or T. It drives an output pin through a tristate enable. It also returns six feedback bits to the shared array.

Each register has its own reset term and its own clock term. A configuration bit lets either register take the dedicated pin clock instead of its clock term. The second register can be bypassed, so that its sum input goes straight back to the array as buried combinational feedback. A merge option turns the three four-term sums into one twelve-term sum. A synchronous preset term, shared with neighbouring cells, forces both registers high at their next clock edge. The configuration word is static. It changes only while the register clock sources are low.

Top module: `mc_cell`

## Requirements
- R1: Sums are formed from the product-term bits: sum A is the OR of pt[3:0] and feeds register 1; sum B is the OR of pt[7:4] and feeds register 2; sum C is the OR of pt[11:8] and feeds the combinational output path. When cfg_bits[7] (merge) is 1, all three uses take the OR of pt[11:0].
- R2: With its type bit at 0 (cfg_bits[6] for register 1, cfg_bits[5] for register 2), a register loads its sum on its active clock edge.
- R3: With its type bit at 1, a register inverts its state on its active clock edge when its sum is 1, and holds its state when the sum is 0.
- R4: Register 1 is clocked by pin_clk when cfg_bits[4] is 1, and by pt[13] otherwise. Register 2 is clocked by pin_clk when cfg_bits[3] is 1, and by pt[14] otherwise. Edges on the source that is not selected leave the register unchanged.
- R5: pt[12] clears register 1 and pt[15] clears register 2, at once and with no clock. Each term leaves the other register untouched. A clear wins over the preset.
- R6: When grp_preset is 1 at a register's active edge, that register becomes 1, whatever its mode or sum.
- R7: While por_n is 0, both registers are held at 0.
- R8: When cfg_bits[2] is 1, the register-2 feedback carries sum B directly. When cfg_bits[2] is 0, it carries register 2's state.
- R9: fb is {F2, ~F2, Q1, ~Q1, pad_in, ~pad_in} from bit 5 down to bit 0, where F2 is the register-2 feedback and Q1 is register 1's state.
- R10: pad_oe equals pt[16]. pad_out is Q1 when cfg_bits[1] is 0, or sum C when cfg_bits[1] is 1. The result is inverted when cfg_bits[0] is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| por_n | input | 1 | Power-on reset, active low, clears both registers |
| pin_clk | input | 1 | Dedicated pin clock |
| pt | input | 17 | Product terms: [11:0] sums, 12 clear 1, 13 clock 1, 14 clock 2, 15 clear 2, 16 output enable |
| grp_preset | input | 1 | Group synchronous preset term |
| cfg_bits | input | 8 | Configuration: 7 merge, 6 T1, 5 T2, 4 pin clock 1, 3 pin clock 2, 2 bypass 2, 1 comb select, 0 invert |
| pad_in | input | 1 | Value observed at the pin |
| pad_out | output | 1 | Data to the pin driver |
| pad_oe | output | 1 | Pin driver enable |
| fb | output | 6 | Feedback to the shared array |

## Verification
The bench pulses each product-term clock on its own while the pin clock keeps running. A cell that mixed up the clock sources would move a register on the wrong clock, and its Q1 or F2 feedback would drift from the model. It holds a clear term high together with the preset and full sums. A design that let the preset win would show a 1 on the cleared register, and one that wired the clear terms wrongly would also clear the other register. With merge set, it walks a single product-term bit across all twelve positions, so a sum left partly unmerged shows up as a wrong output or a wrong register value. In T mode, it runs random sums through both registers, so a register that loaded its sum instead of toggling would depart from the model within a few cycles.

// File: rtl/mc_pkg.sv
package mc_pkg;

  // Static configuration word of one cell, MSB first.
  typedef struct packed {
    logic merge;     // one wide sum for every use
    logic t1;        // register 1 toggles instead of loading
    logic t2;        // register 2 toggles instead of loading
    logic pinclk1;   // register 1 on the pin clock
    logic pinclk2;   // register 2 on the pin clock
    logic bypass2;   // F2 is the register-2 sum, not its state
    logic sel_comb;  // output path takes sum C instead of Q1
    logic invert;    // output polarity
  } mc_cfg_t;

  localparam int CFG_W = $bits(mc_cfg_t);
  localparam int FB_W  = 6;

endpackage

// File: rtl/mc_sum_net.sv
module mc_sum_net #(
  parameter int NSUM   = 3,
  parameter int PT_PER = 4
) (
  input  logic [NSUM*PT_PER-1:0] pt_sum,
  input  logic                   merge,
  output logic [NSUM-1:0]        sums
);

  logic wide_or;

  assign wide_or = |pt_sum;

  genvar g;
  generate
    for (g = 0; g < NSUM; g++) begin : g_sum
      logic narrow_or;
      assign narrow_or = |pt_sum[g*PT_PER +: PT_PER];
      assign sums[g]   = merge ? wide_or : narrow_or;
    end
  endgenerate

endmodule

// File: rtl/mc_flop.sv
module mc_flop (
  input  logic clk,
  input  logic arst_n,
  input  logic t_mode,
  input  logic s_in,
  input  logic preset,
  output logic q
);

  logic q_nxt;

  always_comb begin
    if (preset) begin
      q_nxt = 1'b1;
    end else if (t_mode) begin
      q_nxt = q ^ s_in;
    end else begin
      q_nxt = s_in;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_nxt;
    end
  end

  // R6
  preset_sets_chk : assert property (@(posedge clk) disable iff (!arst_n)
    preset |=> q);

  // R3
  toggle_flip_chk : assert property (@(posedge clk) disable iff (!arst_n)
    (t_mode && s_in && !preset) |=> (q != $past(q)));

  // R2
  d_load_chk : assert property (@(posedge clk) disable iff (!arst_n)
    (!t_mode && !preset) |=> (q == $past(s_in)));

  // R5
  async_clr_chk : assert property (@(posedge clk)
    !arst_n |-> !q);

endmodule

// File: rtl/mc_cell.sv
module mc_cell #(
  parameter int NSUM   = 3,
  parameter int PT_PER = 4,
  localparam int NSP   = NSUM * PT_PER,
  localparam int NPT   = NSP + 5
) (
  input  logic                     por_n,
  input  logic                     pin_clk,
  input  logic [NPT-1:0]           pt,
  input  logic                     grp_preset,
  input  logic [mc_pkg::CFG_W-1:0] cfg_bits,
  input  logic                     pad_in,
  output logic                     pad_out,
  output logic                     pad_oe,
  output logic [mc_pkg::FB_W-1:0]  fb
);

  import mc_pkg::*;

  localparam int I_AR1 = NSP;
  localparam int I_CK1 = NSP + 1;
  localparam int I_CK2 = NSP + 2;
  localparam int I_AR2 = NSP + 3;
  localparam int I_OE  = NSP + 4;

  mc_cfg_t         cfg;
  logic [NSUM-1:0] sums;
  logic            clk1, clk2;
  logic            arst1_n, arst2_n;
  logic            q1, q2;
  logic            f2, out_pre;

  assign cfg = mc_cfg_t'(cfg_bits);

  mc_sum_net #(.NSUM(NSUM), .PT_PER(PT_PER)) u_sums (
    .pt_sum (pt[NSP-1:0]),
    .merge  (cfg.merge),
    .sums   (sums)
  );

  // clock source and clear per register
  assign clk1    = cfg.pinclk1 ? pin_clk : pt[I_CK1];
  assign clk2    = cfg.pinclk2 ? pin_clk : pt[I_CK2];
  assign arst1_n = por_n & ~pt[I_AR1];
  assign arst2_n = por_n & ~pt[I_AR2];

  mc_flop u_reg1 (
    .clk    (clk1),
    .arst_n (arst1_n),
    .t_mode (cfg.t1),
    .s_in   (sums[0]),
    .preset (grp_preset),
    .q      (q1)
  );

  mc_flop u_reg2 (
    .clk    (clk2),
    .arst_n (arst2_n),
    .t_mode (cfg.t2),
    .s_in   (sums[1]),
    .preset (grp_preset),
    .q      (q2)
  );

  always_comb begin
    f2      = cfg.bypass2 ? sums[1] : q2;
    out_pre = cfg.sel_comb ? sums[2] : q1;
  end

  assign pad_out = out_pre ^ cfg.invert;
  assign pad_oe  = pt[I_OE];
  assign fb      = {f2, ~f2, q1, ~q1, pad_in, ~pad_in};

endmodule

// File: tb/sim_mc_cell.sv
module sim_mc_cell;

  logic        clk = 1'b0;
  logic        por_n;
  logic [16:0] pt;
  logic        preset;
  logic [7:0]  cfgb;
  logic        pad_in;
  logic        pad_out, pad_oe;
  logic [5:0]  fb;

  int    nchk = 0;
  int    nfail = 0;
  string cur = "R7";
  logic  q1m, q2m;

  always #10 clk = ~clk;

  mc_cell u0 (
    .por_n      (por_n),
    .pin_clk    (clk),
    .pt         (pt),
    .grp_preset (preset),
    .cfg_bits   (cfgb),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .fb         (fb)
  );

  function automatic logic sum_of(input int g);
    if (cfgb[7]) return |pt[11:0];
    return |pt[g*4 +: 4];
  endfunction

  function automatic logic nextq(input logic q, input logic t, input logic s, input logic pre);
    if (pre) return 1'b1;
    if (t) return q ^ s;
    return s;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic async_model();
    if (!por_n) begin q1m = 1'b0; q2m = 1'b0; end
    if (pt[12]) q1m = 1'b0;
    if (pt[15]) q2m = 1'b0;
  endtask

  task automatic compare();
    logic f2;
    f2 = cfgb[2] ? sum_of(1) : q2m;
    chk(cur, {pad_oe, pad_out, fb},
        {pt[16], (cfgb[1] ? sum_of(2) : q1m) ^ cfgb[0], f2, ~f2, q1m, ~q1m, pad_in, ~pad_in});
  endtask

  // pin-clocked registers of the model
  always @(posedge clk) begin
    if (por_n) begin
      if (cfgb[4]) q1m = nextq(q1m, cfgb[6], sum_of(0), preset);
      if (cfgb[3]) q2m = nextq(q2m, cfgb[5], sum_of(1), preset);
    end
    async_model();
  end

  task automatic step(input logic [16:0] npt, input logic npre);
    @(negedge clk);
    compare();
    #2;
    pt     = npt;
    preset = npre;
    pad_in = 1'($urandom);
    async_model();
  endtask

  task automatic set_cfg(input logic [7:0] v);
    @(negedge clk);
    compare();
    #2;
    cfgb = v;
  endtask

  // raises or lowers only the product-term clock bits
  task automatic ptclk(input logic c1, input logic c2);
    logic r1, r2;
    @(negedge clk);
    compare();
    #2;
    r1 = c1 & ~pt[13];
    r2 = c2 & ~pt[14];
    pt[13] = c1;
    pt[14] = c2;
    if (r1 && !cfgb[4] && por_n) q1m = nextq(q1m, cfgb[6], sum_of(0), preset);
    if (r2 && !cfgb[3] && por_n) q2m = nextq(q2m, cfgb[5], sum_of(1), preset);
    async_model();
  endtask

  function automatic logic [16:0] rnd_pt(input logic sparse);
    logic [16:0] v;
    v = 17'($urandom);
    if (sparse) v = v & 17'($urandom) & 17'($urandom);
    return v & 17'h10FFF;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    por_n  = 1'b0;
    pt     = '0;
    preset = 1'b0;
    pad_in = 1'b0;
    cfgb   = 8'h18;
    q1m    = 1'b0;
    q2m    = 1'b0;

    // R7: registers held low while por_n is low, even with preset and data
    cur = "R7";
    step(17'h00FFF, 1'b1);
    step(rnd_pt(0), 1'b1);
    step(rnd_pt(0), 1'b0);
    @(negedge clk);
    chk("R7 q1 at reset", {7'd0, fb[3]}, 8'd0);
    #2 por_n = 1'b1;

    // R2: D mode on the pin clock
    cur = "R2";
    for (int i = 0; i < 16; i++) step(rnd_pt(0), 1'b0);

    // R3: T mode on the pin clock
    cur = "R3";
    set_cfg(8'h78);
    for (int i = 0; i < 16; i++) step(rnd_pt(1), 1'b0);

    // R1: merged sum, one product term at a time
    cur = "R1";
    set_cfg(8'h98);
    for (int k = 0; k < 12; k++) begin
      step(17'(1 << k), 1'b0);
      step(17'h0, 1'b0);
    end
    set_cfg(8'h1A);
    for (int i = 0; i < 10; i++) step(rnd_pt(1), 1'b0);

    // R10: output select and polarity
    cur = "R10";
    set_cfg(8'h1B);
    for (int i = 0; i < 8; i++) step(rnd_pt(1), 1'b0);
    set_cfg(8'h19);
    for (int i = 0; i < 8; i++) step(rnd_pt(0), 1'b0);

    // R8: buried combinational feedback
    cur = "R8";
    set_cfg(8'h1C);
    for (int i = 0; i < 10; i++) step(rnd_pt(1), 1'b0);

    // R6: preset in D and in T mode
    cur = "R6";
    set_cfg(8'h18);
    for (int i = 0; i < 4; i++) step(rnd_pt(1), 1'b1);
    step(17'h0, 1'b0);
    set_cfg(8'h78);
    for (int i = 0; i < 4; i++) step(rnd_pt(0), 1'b1);
    step(17'h0, 1'b0);

    // R5: clear terms beat the preset and touch only their own register
    cur = "R5";
    set_cfg(8'h18);
    for (int i = 0; i < 3; i++) step(17'h01FFF, 1'b1);
    @(negedge clk);
    chk("R5 clear1 over preset", {6'd0, fb[5], fb[3]}, 8'b10);
    for (int i = 0; i < 3; i++) step(17'h08FFF, 1'b1);
    @(negedge clk);
    chk("R5 clear2 over preset", {6'd0, fb[5], fb[3]}, 8'b01);
    step(17'h0, 1'b0);
    step(17'h0, 1'b0);

    // R9: feedback ordering with the pin moving
    cur = "R9";
    for (int i = 0; i < 8; i++) step(rnd_pt(0), 1'b0);

    // R4: product-term clocks, pin clock has no effect
    cur = "R4";
    step(rnd_pt(0) & 17'h10FFF, 1'b0);
    set_cfg(8'h00);
    for (int i = 0; i < 4; i++) step(rnd_pt(0), 1'b0);
    for (int i = 0; i < 6; i++) begin
      step(rnd_pt(0), 1'b0);
      ptclk(1'b1, 1'b0);
      ptclk(1'b0, 1'b0);
      step(rnd_pt(0), 1'b0);
      ptclk(1'b0, 1'b1);
      ptclk(1'b0, 1'b0);
    end
    set_cfg(8'h60);
    for (int i = 0; i < 6; i++) begin
      step(rnd_pt(1), 1'b0);
      ptclk(1'b1, 1'b1);
      ptclk(1'b0, 1'b0);
    end

    @(negedge clk);
    compare();
    finish_run();
  end

endmodule